// File: doc/BRIEF.md
# Receive Buffer Identifier Manager

This block recycles packet-buffer identifiers between software and a USB receive engine for OUT and SETUP transactions. Software hands free 5-bit buffer identifiers (each naming one of 32 buffers of 64 bytes) to a four-entry free-ID queue. The receive engine announces each new OUT or SETUP transaction with `pkt_start`. If there is no free ID, or there is no room to report a finished packet, the block asks for a NACK. Otherwise the engine receives into the buffer shown on `pkt_buf_id`. On `pkt_done` the block takes that ID from the free-ID queue and writes a descriptor into a four-entry completion queue. On `pkt_err` it drops the packet and keeps the ID for the next transaction.

Software pops one completion descriptor per `rxq_rd` pulse. The descriptor at the head is always visible on `rxq_desc`. Queue depths, a full flag, an empty flag and single-cycle event pulses are reported at the ports.

A small controller has two states. In `ST_IDLE` it waits for `pkt_start`. A start that is refused returns to `ST_IDLE` with a NACK. A start that is accepted moves to `ST_RECV`. In `ST_RECV`, `pkt_err` returns to `ST_IDLE` and nothing is stored. `pkt_done` returns to `ST_IDLE` after popping the free-ID queue and pushing a completion descriptor.

Top module: `rx_buf_mgr`

## Requirements
- R1: After reset, `av_depth` is 0, `av_full` is 0, `rxq_depth` is 0, `rxq_empty` is 1, and every event output is 0.
- R2: A write with `av_wr` while the free-ID queue holds fewer than 4 entries appends `av_wr_id`. `av_depth` increases by one in the next cycle, and `av_full` is 1 exactly when the depth is 4.
- R3: A write while the free-ID queue holds 4 entries is discarded. `ev_av_overflow` pulses in that same cycle, the depth stays at 4, and the queued IDs are unchanged.
- R4: A `pkt_start` in `ST_IDLE` while the free-ID queue is empty raises `pkt_nack` and `ev_av_empty` in the same cycle. No reception begins, so a following `pkt_done` pushes nothing.
- R5: A `pkt_start` in `ST_IDLE` while the completion queue holds 4 descriptors raises `pkt_nack` and `ev_rxq_full` in the same cycle, and no reception begins.
- R6: An accepted `pkt_start` leaves `pkt_nack` at 0, and `pkt_buf_id` shows the oldest free ID. A `pkt_done` in `ST_RECV` pulses `ev_pkt_received` in that cycle. In the next cycle `av_depth` has dropped by one and `rxq_depth` has risen by one.
- R7: Descriptor layout: bits 4:0 hold the buffer ID, bits 14:8 hold the byte count (`pkt_size`), bit 19 is 1 for SETUP and 0 for OUT (`pkt_setup`), bits 23:20 hold the endpoint (`pkt_ep`), and all other bits are 0.
- R8: `rxq_desc` shows the oldest descriptor, and an `rxq_rd` pulse pops it. While the completion queue is empty, `rxq_desc` reads 0 and `rxq_rd` has no effect.
- R9: A `pkt_err` in `ST_RECV` stores nothing and consumes no ID. The same ID is offered again at the next accepted `pkt_start`.
- R10: A push and a pop on the same queue in the same cycle leave its depth unchanged.
- R11: Both queues are first-in first-out. IDs are used in the order they were written, and descriptors are read in the order the packets completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| av_wr | input | 1 | Software write into the free-ID queue |
| av_wr_id | input | 5 | Buffer ID being freed |
| rxq_rd | input | 1 | Software read of the completion queue (pops) |
| rxq_desc | output | 32 | Head completion descriptor, 0 when empty |
| pkt_start | input | 1 | OUT/SETUP transaction start from the receive engine |
| pkt_nack | output | 1 | Transaction must be NACKed |
| pkt_buf_id | output | 5 | Buffer ID to receive into |
| pkt_done | input | 1 | Packet finished without error |
| pkt_err | input | 1 | Packet dropped because of an error (wins over pkt_done) |
| pkt_setup | input | 1 | Finished packet was SETUP (1) or OUT (0) |
| pkt_ep | input | 4 | Endpoint of the finished packet |
| pkt_size | input | 7 | Byte count of the finished packet |
| av_depth | output | 3 | Entries in the free-ID queue |
| av_full | output | 1 | Free-ID queue is full |
| rxq_depth | output | 3 | Entries in the completion queue |
| rxq_empty | output | 1 | Completion queue is empty |
| ev_av_overflow | output | 1 | Pulse: write to a full free-ID queue was discarded |
| ev_av_empty | output | 1 | Pulse: NACK because no free ID was available |
| ev_rxq_full | output | 1 | Pulse: NACK because the completion queue was full |
| ev_pkt_received | output | 1 | Pulse: a descriptor was stored |

## Verification
A wrong pointer or count inside either queue shows up at the ports within one cycle. The depth output reads differently in the cycle after the faulty update, and at the next pop the wrong ID appears on `pkt_buf_id` or the wrong descriptor appears on `rxq_desc`. A controller stuck in the wrong state is revealed the first time the engine signals an outcome. An extra or missing `ev_pkt_received` pulse appears in that same cycle, and the completion depth reads wrong one cycle later. The tests therefore read depths one cycle after each action, and they read the head contents only at the points where the first-in first-out order and the reuse of a dropped ID can be told apart.

// File: rtl/rxbm_pkg.sv
package rxbm_pkg;
    parameter int ID_W    = 5;
    parameter int SIZE_W  = 7;
    parameter int EP_W    = 4;
    parameter int QDEPTH  = 4;
    parameter int CNT_W   = $clog2(QDEPTH + 1);
    parameter int DESC_W  = 32;

    // Descriptor bit positions seen by software
    parameter int POS_ID    = 0;
    parameter int POS_SIZE  = 8;
    parameter int POS_SETUP = 19;
    parameter int POS_EP    = 20;

    typedef struct packed {
        logic              setup;
        logic [EP_W-1:0]   ep;
        logic [SIZE_W-1:0] size;
        logic [ID_W-1:0]   id;
    } rx_desc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } ctl_state_e;

    function automatic logic [DESC_W-1:0] pack_desc(input rx_desc_t d);
        logic [DESC_W-1:0] w;
        w = '0;
        w[POS_ID    +: ID_W]   = d.id;
        w[POS_SIZE  +: SIZE_W] = d.size;
        w[POS_SETUP]           = d.setup;
        w[POS_EP    +: EP_W]   = d.ep;
        return w;
    endfunction
endpackage

// File: rtl/rxbm_queue.sv
module rxbm_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (do_push && wr_ptr == PW'(i))
                mem[i] <= din;
        end
    end

    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));
    a_r8_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - CW'(1)));
    a_r10_same_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full) |=> $stable(count));
endmodule

// File: rtl/rxbm_ctl.sv
module rxbm_ctl
    import rxbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start,
    input  logic pkt_done,
    input  logic pkt_err,
    input  logic av_empty,
    input  logic rxq_full,
    output logic pkt_nack,
    output logic ev_av_empty,
    output logic ev_rxq_full,
    output logic ev_pkt_received,
    output logic av_pop,
    output logic rxq_push
);
    ctl_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt       = state;
        pkt_nack        = 1'b0;
        ev_av_empty     = 1'b0;
        ev_rxq_full     = 1'b0;
        ev_pkt_received = 1'b0;
        av_pop          = 1'b0;
        rxq_push        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pkt_start) begin
                    if (av_empty || rxq_full) begin
                        pkt_nack    = 1'b1;
                        ev_av_empty = av_empty;
                        ev_rxq_full = rxq_full;
                    end else begin
                        state_nxt = ST_RECV;
                    end
                end
            end
            ST_RECV: begin
                if (pkt_err) begin
                    state_nxt = ST_IDLE;
                end else if (pkt_done) begin
                    av_pop          = 1'b1;
                    rxq_push        = 1'b1;
                    ev_pkt_received = 1'b1;
                    state_nxt       = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    a_r4_empty_no_recv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pkt_start && av_empty) |=> (state == ST_IDLE));
    a_r5_full_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pkt_start && rxq_full) |-> (pkt_nack && ev_rxq_full));
    a_r6_pop_with_push: assert property (@(posedge clk) disable iff (!rst_n)
        av_pop |-> (rxq_push && !av_empty && !rxq_full));
    a_r9_err_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && pkt_err) |-> (!av_pop && !rxq_push));
endmodule

// File: rtl/rx_buf_mgr.sv
module rx_buf_mgr
    import rxbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              av_wr,
    input  logic [ID_W-1:0]   av_wr_id,
    input  logic              rxq_rd,
    output logic [DESC_W-1:0] rxq_desc,
    input  logic              pkt_start,
    output logic              pkt_nack,
    output logic [ID_W-1:0]   pkt_buf_id,
    input  logic              pkt_done,
    input  logic              pkt_err,
    input  logic              pkt_setup,
    input  logic [EP_W-1:0]   pkt_ep,
    input  logic [SIZE_W-1:0] pkt_size,
    output logic [CNT_W-1:0]  av_depth,
    output logic              av_full,
    output logic [CNT_W-1:0]  rxq_depth,
    output logic              rxq_empty,
    output logic              ev_av_overflow,
    output logic              ev_av_empty,
    output logic              ev_rxq_full,
    output logic              ev_pkt_received
);
    logic     av_pop, av_empty_w, rxq_push, rxq_full_w;
    rx_desc_t new_desc, head_desc;

    rxbm_queue #(.W(ID_W), .DEPTH(QDEPTH)) u_avq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (av_wr),
        .din   (av_wr_id),
        .pop   (av_pop),
        .dout  (pkt_buf_id),
        .count (av_depth),
        .full  (av_full),
        .empty (av_empty_w)
    );

    always_comb begin
        new_desc.id    = pkt_buf_id;
        new_desc.size  = pkt_size;
        new_desc.setup = pkt_setup;
        new_desc.ep    = pkt_ep;
    end

    rxbm_queue #(.W($bits(rx_desc_t)), .DEPTH(QDEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rxq_push),
        .din   (new_desc),
        .pop   (rxq_rd),
        .dout  (head_desc),
        .count (rxq_depth),
        .full  (rxq_full_w),
        .empty (rxq_empty)
    );

    rxbm_ctl u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .pkt_start       (pkt_start),
        .pkt_done        (pkt_done),
        .pkt_err         (pkt_err),
        .av_empty        (av_empty_w),
        .rxq_full        (rxq_full_w),
        .pkt_nack        (pkt_nack),
        .ev_av_empty     (ev_av_empty),
        .ev_rxq_full     (ev_rxq_full),
        .ev_pkt_received (ev_pkt_received),
        .av_pop          (av_pop),
        .rxq_push        (rxq_push)
    );

    assign ev_av_overflow = av_wr && av_full;
    assign rxq_desc       = rxq_empty ? '0 : pack_desc(head_desc);

    a_r8_empty_desc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_empty |-> (rxq_desc == '0));
    a_r6_event_grows_rxq: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pkt_received && !rxq_rd) |=> (rxq_depth == $past(rxq_depth) + CNT_W'(1)));
endmodule

// File: tb/sim_rx_buf_mgr.sv
module sim_rx_buf_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        av_wr = 1'b0;
    logic [4:0]  av_wr_id = '0;
    logic        rxq_rd = 1'b0;
    logic [31:0] rxq_desc;
    logic        pkt_start = 1'b0;
    logic        pkt_nack;
    logic [4:0]  pkt_buf_id;
    logic        pkt_done = 1'b0;
    logic        pkt_err = 1'b0;
    logic        pkt_setup = 1'b0;
    logic [3:0]  pkt_ep = '0;
    logic [6:0]  pkt_size = '0;
    logic [2:0]  av_depth, rxq_depth;
    logic        av_full, rxq_empty;
    logic        ev_av_overflow, ev_av_empty, ev_rxq_full, ev_pkt_received;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rx_buf_mgr u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] desc(input logic [4:0] id, input logic [6:0] sz,
                                         input logic setup, input logic [3:0] ep);
        return {8'h00, ep, setup, 4'h0, sz, 3'b000, id};
    endfunction

    task automatic push_id(input logic [4:0] id, input logic exp_ovf);
        @(negedge clk);
        av_wr = 1'b1; av_wr_id = id;
        #2 chk("R3 overflow event", 32'(ev_av_overflow), 32'(exp_ovf));
        @(negedge clk);
        av_wr = 1'b0;
    endtask

    task automatic start_pkt(input logic exp_nack, input logic exp_aemp, input logic exp_rfull,
                             input logic [4:0] exp_id, input string req);
        @(negedge clk);
        pkt_start = 1'b1;
        #2;
        chk({req, " nack"}, 32'(pkt_nack), 32'(exp_nack));
        chk({req, " av empty event"}, 32'(ev_av_empty), 32'(exp_aemp));
        chk({req, " rxq full event"}, 32'(ev_rxq_full), 32'(exp_rfull));
        if (!exp_nack) chk({req, " buffer id"}, 32'(pkt_buf_id), 32'(exp_id));
        @(negedge clk);
        pkt_start = 1'b0;
    endtask

    task automatic end_pkt(input logic err, input logic setup, input logic [3:0] ep,
                           input logic [6:0] sz, input logic exp_ev, input logic also_push,
                           input logic [4:0] push_val, input string req);
        @(negedge clk);
        pkt_err = err; pkt_done = ~err;
        pkt_setup = setup; pkt_ep = ep; pkt_size = sz;
        av_wr = also_push; av_wr_id = push_val;
        #2 chk({req, " received event"}, 32'(ev_pkt_received), 32'(exp_ev));
        @(negedge clk);
        pkt_err = 1'b0; pkt_done = 1'b0; av_wr = 1'b0;
    endtask

    task automatic read_desc(input logic [31:0] exp, input logic [2:0] exp_depth_after,
                             input string req);
        @(negedge clk);
        #2 chk({req, " head descriptor"}, rxq_desc, exp);
        rxq_rd = 1'b1;
        @(negedge clk);
        rxq_rd = 1'b0;
        chk({req, " depth after read"}, 32'(rxq_depth), 32'(exp_depth_after));
    endtask

    task automatic t_reset;
        chk("R1 av_depth", 32'(av_depth), 0);
        chk("R1 av_full", 32'(av_full), 0);
        chk("R1 rxq_depth", 32'(rxq_depth), 0);
        chk("R1 rxq_empty", 32'(rxq_empty), 1);
        chk("R1 events", 32'({ev_av_overflow, ev_av_empty, ev_rxq_full, ev_pkt_received}), 0);
    endtask

    task automatic t_empty_nack;
        start_pkt(1'b1, 1'b1, 1'b0, 5'd0, "R4");
        end_pkt(1'b0, 1'b0, 4'd1, 7'd8, 1'b0, 1'b0, 5'd0, "R4 done ignored");
        chk("R4 nothing stored", 32'(rxq_depth), 0);
    endtask

    task automatic t_fill_overflow;
        push_id(5'd5, 1'b0);
        chk("R2 depth 1", 32'(av_depth), 1);
        push_id(5'd6, 1'b0);
        push_id(5'd7, 1'b0);
        chk("R2 not yet full", 32'(av_full), 0);
        push_id(5'd8, 1'b0);
        chk("R2 depth 4", 32'(av_depth), 4);
        chk("R2 full flag", 32'(av_full), 1);
        push_id(5'd9, 1'b1);
        chk("R3 depth held", 32'(av_depth), 4);
    endtask

    task automatic t_receive_and_drop;
        start_pkt(1'b0, 1'b0, 1'b0, 5'd5, "R6 first");
        end_pkt(1'b0, 1'b1, 4'd3, 7'd64, 1'b1, 1'b0, 5'd0, "R6");
        chk("R6 av depth down", 32'(av_depth), 3);
        chk("R6 rxq depth up", 32'(rxq_depth), 1);
        start_pkt(1'b0, 1'b0, 1'b0, 5'd6, "R9 start");
        end_pkt(1'b1, 1'b0, 4'd2, 7'd10, 1'b0, 1'b0, 5'd0, "R9 error");
        chk("R9 av depth kept", 32'(av_depth), 3);
        chk("R9 rxq depth kept", 32'(rxq_depth), 1);
        start_pkt(1'b0, 1'b0, 1'b0, 5'd6, "R9 id reused");
        end_pkt(1'b0, 1'b0, 4'd15, 7'd0, 1'b1, 1'b0, 5'd0, "R11 second");
        start_pkt(1'b0, 1'b0, 1'b0, 5'd7, "R11 third");
        end_pkt(1'b0, 1'b0, 4'd9, 7'd33, 1'b1, 1'b0, 5'd0, "R11 third");
        start_pkt(1'b0, 1'b0, 1'b0, 5'd8, "R11 fourth");
        end_pkt(1'b0, 1'b1, 4'd0, 7'd1, 1'b1, 1'b0, 5'd0, "R11 fourth");
        chk("R6 av drained", 32'(av_depth), 0);
        chk("R6 rxq holds four", 32'(rxq_depth), 4);
    endtask

    task automatic t_rxq_full;
        push_id(5'd10, 1'b0);
        start_pkt(1'b1, 1'b0, 1'b1, 5'd0, "R5");
        chk("R5 av id not taken", 32'(av_depth), 1);
        chk("R5 rxq still four", 32'(rxq_depth), 4);
    endtask

    task automatic t_order_and_simul;
        read_desc(desc(5'd5, 7'd64, 1'b1, 4'd3), 3'd3, "R7 R11 first");
        start_pkt(1'b0, 1'b0, 1'b0, 5'd10, "R10 start");
        end_pkt(1'b0, 1'b0, 4'd4, 7'd17, 1'b1, 1'b1, 5'd11, "R10");
        chk("R10 av depth unchanged", 32'(av_depth), 1);
        chk("R10 rxq depth", 32'(rxq_depth), 4);
        read_desc(desc(5'd6, 7'd0, 1'b0, 4'd15), 3'd3, "R7 R11 second");
        read_desc(desc(5'd7, 7'd33, 1'b0, 4'd9), 3'd2, "R11 third");
        read_desc(desc(5'd8, 7'd1, 1'b1, 4'd0), 3'd1, "R11 fourth");
        read_desc(desc(5'd10, 7'd17, 1'b0, 4'd4), 3'd0, "R11 fifth");
        chk("R8 empty flag", 32'(rxq_empty), 1);
        read_desc(32'h0, 3'd0, "R8 read of empty queue");
        start_pkt(1'b0, 1'b0, 1'b0, 5'd11, "R11 id after simultaneous push");
        end_pkt(1'b1, 1'b0, 4'd0, 7'd0, 1'b0, 1'b0, 5'd0, "R9 second drop");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #5;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_nack();
        t_fill_overflow();
        t_receive_and_drop();
        t_rxq_full();
        t_order_and_simul();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        summary();
    end
endmodule